// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Core

This block is the digital half of an 8-bit successive-approximation converter that a host drives over a four-wire serial link. The host pulls the select line low. It clocks in a start bit followed by a short assignment word that picks the input channel and the input mode. The block then steers an external analog multiplexer, presents trial codes to an external ladder, and reads a one-bit comparator verdict for each trial. Every result bit is sent to the host on the serial output in the clock period in which it is decided.

After the most significant bit first stream, the same result is sent again starting from the least significant bit. On the 8-channel build, a hold input can keep the least significant bit on the line and delay this replay. A status flag is high while the search runs, and the serial input is ignored from the moment the channel is latched. The serial clock, select, data and hold inputs are treated as signals that are synchronous to the fabric clock. Serial clock edges are found by comparing the current serial clock level with the level stored in the previous fabric cycle. Output enables are brought out separately so that the pads can tri-state the output and status lines.

Top module: `sser_adc_ctrl`

## Requirements
- R1: While `cs_n` is high, one fabric cycle later `sdo_oe`, `busy_oe` and `busy` are all 0, and all internal state is cleared.
- R2: After `cs_n` falls, serial clock rises that sample `sdi` low are ignored. The first rise that samples `sdi` high is taken as the start bit.
- R3: The bits after the start bit arrive in this order: mode (1 = single-ended), odd, then the select bits with the most significant first (two select bits on 8 channels). In single-ended mode, `pos_ch` = {select bits, odd} and `neg_com` = 1, so the negative input is the common terminal.
- R4: In differential mode, `pos_ch` = {select bits, odd}, `neg_ch` = {select bits, ~odd} and `neg_com` = 0. Each channel therefore pairs only with its even/odd neighbour.
- R5: `busy` goes high on the rise that samples the last assignment bit. From then until `cs_n` goes high, `sdi` has no effect, and `pos_ch`, `neg_ch` and `neg_com` hold their values.
- R6: On the next serial clock fall after the channel is latched, `sdo_oe` goes high and `sdo` drives 0 for one serial clock period. This is the settling slot.
- R7: On each of the following 8 falls, one result bit is driven on `sdo`, most significant bit first. The bits form the largest code that does not exceed the positive input minus the negative input. If the positive input is below the negative input, the result is all zeros.
- R8: `busy` is still high after the fall that sends bit 1. It goes low on the fall that sends the least significant bit.
- R9: On the 7 falls after the least significant bit, bits 1 through 7 are sent in ascending order. Any later fall leaves `sdo` unchanged, and `sdo_oe` stays high.
- R10: On the 8-channel build, a fall that comes while `hold_lsb` is high in the replay phase leaves the current bit on `sdo`. The replay continues with the next bit once `hold_lsb` is low.
- R11: With `CHANNELS`=4, the assignment word is 3 bits long (mode, odd, one select bit), `pos_ch` = {select, odd}, and `hold_lsb` has no effect.
- R12: If `cs_n` goes high during a conversion, the conversion stops and both outputs go high impedance. After the next fall of `cs_n`, no conversion starts until a new start bit and assignment word are received.
- R13: `trial` is 0 outside a conversion. When the channel is latched, `trial` is 0x80, so the bit under test is set before it is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Transaction select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial start bit and assignment word |
| hold_lsb | input | 1 | Keeps the least significant bit on the line during replay (8-channel build only) |
| cmp_hi | input | 1 | Comparator verdict: positive input minus negative input is at least the trial code |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| busy | output | 1 | Search in progress |
| busy_oe | output | 1 | Output enable for `busy` |
| pos_ch | output | CHW | Channel routed to the positive comparator input |
| neg_ch | output | CHW | Channel routed to the negative input when `neg_com` is 0 |
| neg_com | output | 1 | Negative input taken from the common terminal |
| trial | output | RES | Code presented to the ladder |

## Verification
The bench first sends low bits before the start bit. A design that took the first rise as the start would latch the wrong channel and start early. It then toggles `sdi` high during the search: a design that kept shifting after the latch would change `pos_ch` and corrupt the comparison. The replay is driven one clock past its end, with `hold_lsb` raised in the middle, and once on the 4-channel build where the hold must have no effect. An off-by-one index in the replay register, or a replay that wraps, shows up as a wrong bit. Each bench input also includes a conversion that is aborted by `cs_n`, followed by bare clocks that must not start a new one, and a differential input with reversed polarity that must give all zeros.

// File: rtl/sser_pkg.sv
package sser_pkg;

   // Transaction phases of the serial converter controller
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_SETTLE,
      PH_CONV,
      PH_REPLAY,
      PH_DONE
   } phase_e;

endpackage

// File: rtl/sser_addr_capture.sv
// Start-bit hunt and assignment-word capture; latches the channel routing.
module sser_addr_capture #(
   parameter  int CHANNELS = 8,
   localparam int CHW      = $clog2(CHANNELS),
   localparam int NFIELD   = CHW + 1,
   localparam int CW       = $clog2(NFIELD)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           en,
   input  logic           rise,
   input  logic           sdi,
   output logic           done,
   output logic [CHW-1:0] pos_ch,
   output logic [CHW-1:0] neg_ch,
   output logic           neg_com
);

   logic              started;
   logic [CW-1:0]     cnt;
   logic [NFIELD-2:0] sh;
   logic [NFIELD-1:0] word;
   logic              take;

   assign take = en & rise;
   assign done = take & started & (cnt == CW'(NFIELD - 1));
   assign word = {sh, sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         pos_ch  <= '0;
         neg_ch  <= '0;
         neg_com <= 1'b0;
      end else if (clr) begin
         started <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         pos_ch  <= '0;
         neg_ch  <= '0;
         neg_com <= 1'b0;
      end else if (take) begin
         if (!started) begin
            started <= sdi;
            cnt     <= '0;
         end else if (done) begin
            pos_ch  <= {word[NFIELD-3:0],  word[NFIELD-2]};
            neg_ch  <= {word[NFIELD-3:0], ~word[NFIELD-2]};
            neg_com <= word[NFIELD-1];
            started <= 1'b0;
         end else begin
            sh  <= word[NFIELD-2:0];
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sser_sar_engine.sv
// Successive-approximation register: one decision per step, MSB first.
module sser_sar_engine #(
   parameter  int RES = 8,
   localparam int IW  = $clog2(RES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           load,
   input  logic           step,
   input  logic           cmp_hi,
   output logic [RES-1:0] trial,
   output logic           last
);

   logic [RES-1:0] code;
   logic [IW-1:0]  idx;

   assign trial = code;
   assign last  = (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         idx  <= '0;
      end else if (clr) begin
         code <= '0;
         idx  <= '0;
      end else if (load) begin
         code <= {1'b1, {(RES-1){1'b0}}};
         idx  <= IW'(RES - 1);
      end else if (step) begin
         if (idx == '0) begin
            code <= '0;
         end else begin
            code[idx]        <= cmp_hi;
            code[idx - 1'b1] <= 1'b1;
            idx              <= idx - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sser_out_shift.sv
// Serial output path: settling low, MSB-first capture, LSB-first replay.
module sser_out_shift #(
   parameter  int RES     = 8,
   parameter  bit HOLD_EN = 1'b1,
   localparam int IW      = $clog2(RES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic settle,
   input  logic conv_v,
   input  logic conv_bit,
   input  logic replay_step,
   input  logic hold,
   output logic sdo,
   output logic sdo_oe,
   output logic replay_last
);

   logic [RES-1:0] cap;
   logic [IW-1:0]  rcnt;
   logic           gate;
   logic           advance;

   generate
      if (HOLD_EN) begin : g_hold
         assign gate = ~hold;
         AST_HOLD_LSB: assert property (@(posedge clk) disable iff (!rst_n || clr)
            (replay_step && hold) |=> $stable(sdo)); // R10
      end else begin : g_nohold
         assign gate = 1'b1;
      end
   endgenerate

   assign advance     = replay_step & gate;
   assign replay_last = advance & (rcnt == IW'(RES - 2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
         cap    <= '0;
         rcnt   <= '0;
      end else if (clr) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
         cap    <= '0;
         rcnt   <= '0;
      end else if (settle) begin
         sdo_oe <= 1'b1;
         sdo    <= 1'b0;
      end else if (conv_v) begin
         sdo  <= conv_bit;
         cap  <= {cap[RES-2:0], conv_bit};
         rcnt <= '0;
      end else if (advance) begin
         sdo  <= cap[1];
         cap  <= {1'b0, cap[RES-1:1]};
         rcnt <= rcnt + 1'b1;
      end
   end

endmodule

// File: rtl/sser_adc_ctrl.sv
// Top: serial transaction sequencer for the successive-approximation core.
module sser_adc_ctrl
   import sser_pkg::*;
#(
   parameter  int CHANNELS = 8,
   parameter  int RES      = 8,
   localparam int CHW      = $clog2(CHANNELS),
   localparam bit HOLD_EN  = (CHANNELS == 8)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           sclk,
   input  logic           sdi,
   input  logic           hold_lsb,
   input  logic           cmp_hi,
   output logic           sdo,
   output logic           sdo_oe,
   output logic           busy,
   output logic           busy_oe,
   output logic [CHW-1:0] pos_ch,
   output logic [CHW-1:0] neg_ch,
   output logic           neg_com,
   output logic [RES-1:0] trial
);

   generate
      if (CHANNELS != 4 && CHANNELS != 8) begin : g_bad_channels
         $error("sser_adc_ctrl: CHANNELS must be 4 or 8");
      end
      if (RES < 2) begin : g_bad_res
         $error("sser_adc_ctrl: RES must be at least 2");
      end
   endgenerate

   phase_e phase;
   logic   sclk_q;
   logic   rise, fall;
   logic   addr_done, sar_last, replay_last;
   logic   conv_step;

   assign rise      = sclk & ~sclk_q;
   assign fall      = ~sclk & sclk_q;
   assign conv_step = fall && (phase == PH_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         busy    <= 1'b0;
         busy_oe <= 1'b0;
      end else if (cs_n) begin
         phase   <= PH_IDLE;
         busy    <= 1'b0;
         busy_oe <= 1'b0;
      end else begin
         busy_oe <= 1'b1;
         case (phase)
            PH_IDLE:   phase <= PH_ADDR;
            PH_ADDR:   if (addr_done) begin
                          phase <= PH_SETTLE;
                          busy  <= 1'b1;
                       end
            PH_SETTLE: if (fall) phase <= PH_CONV;
            PH_CONV:   if (conv_step && sar_last) begin
                          phase <= PH_REPLAY;
                          busy  <= 1'b0;
                       end
            PH_REPLAY: if (replay_last) phase <= PH_DONE;
            default:   phase <= PH_DONE;
         endcase
      end
   end

   sser_addr_capture #(.CHANNELS(CHANNELS)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cs_n),
      .en      (phase == PH_ADDR),
      .rise    (rise),
      .sdi     (sdi),
      .done    (addr_done),
      .pos_ch  (pos_ch),
      .neg_ch  (neg_ch),
      .neg_com (neg_com)
   );

   sser_sar_engine #(.RES(RES)) u_sar (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cs_n),
      .load   (addr_done),
      .step   (conv_step),
      .cmp_hi (cmp_hi),
      .trial  (trial),
      .last   (sar_last)
   );

   sser_out_shift #(.RES(RES), .HOLD_EN(HOLD_EN)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (cs_n),
      .settle      (fall && (phase == PH_SETTLE)),
      .conv_v      (conv_step),
      .conv_bit    (cmp_hi),
      .replay_step (fall && (phase == PH_REPLAY)),
      .hold        (hold_lsb),
      .sdo         (sdo),
      .sdo_oe      (sdo_oe),
      .replay_last (replay_last)
   );

   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!sdo_oe && !busy_oe && !busy)); // R1

   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
      (busy && $past(busy)) |-> ($stable(pos_ch) && $stable(neg_ch) && $stable(neg_com))); // R5

   AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> !sdo); // R6

   AST_TRIAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
      !busy |-> (trial == '0)); // R13

   AST_DONE_STATIC: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
      (phase == PH_DONE && $past(phase) == PH_DONE) |-> $stable(sdo)); // R9

endmodule

// File: tb/sser_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sser_adc_ctrl_bench;

   localparam int H = 6;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, hold_lsb = 1'b0;
   logic cmp8, cmp4;
   logic sdo8, sdo_oe8, busy8, busy_oe8, neg_com8;
   logic [2:0] pos8, neg8;
   logic [7:0] trial8;
   logic sdo4, sdo_oe4, busy4, busy_oe4, neg_com4;
   logic [1:0] pos4, neg4;
   logic [7:0] trial4;

   int ain [0:7];
   int com_v;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   function automatic logic cmp_model(int p, int n, logic [7:0] t);
      return ((p - n) >= int'(t));
   endfunction

   assign cmp8 = cmp_model(ain[pos8], neg_com8 ? com_v : ain[neg8], trial8);
   assign cmp4 = cmp_model(ain[pos4], neg_com4 ? 0 : ain[neg4], trial4);

   sser_adc_ctrl u_sser_adc_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .hold_lsb(hold_lsb),
      .cmp_hi(cmp8), .sdo(sdo8), .sdo_oe(sdo_oe8), .busy(busy8), .busy_oe(busy_oe8),
      .pos_ch(pos8), .neg_ch(neg8), .neg_com(neg_com8), .trial(trial8));

   sser_adc_ctrl #(.CHANNELS(4)) u_sser_adc_ctrl_four (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .hold_lsb(hold_lsb),
      .cmp_hi(cmp4), .sdo(sdo4), .sdo_oe(sdo_oe4), .busy(busy4), .busy_oe(busy_oe4),
      .pos_ch(pos4), .neg_ch(neg4), .neg_com(neg_com4), .trial(trial4));

   task automatic wait_clks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pulse(logic d);
      sdi = d;
      wait_clks(2);
      sclk = 1'b1;
      wait_clks(H);
      sclk = 1'b0;
      wait_clks(H);
   endtask

   function automatic logic sdo_of(bit four);
      return four ? sdo4 : sdo8;
   endfunction

   task automatic cs_begin();
      cs_n = 1'b0;
      wait_clks(3);
   endtask

   task automatic cs_end();
      cs_n = 1'b1;
      sdi  = 1'b0;
      wait_clks(4);
   endtask

   task automatic send_addr8(logic sgl, logic odd, logic s1, logic s0);
      pulse(1'b1); pulse(sgl); pulse(odd); pulse(s1); pulse(s0);
   endtask

   // sdi driven high throughout to show it is locked out
   task automatic read_msb(bit four, output logic [7:0] r, output logic busy_at_bit1);
      busy_at_bit1 = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         pulse(1'b1);
         r[i] = sdo_of(four);
         if (i == 1) busy_at_bit1 = four ? busy4 : busy8;
      end
   endtask

   task automatic check_replay(bit four, string req, logic [7:0] exp);
      for (int i = 1; i < 8; i++) begin
         pulse(1'b0);
         check(req, $sformatf("replay bit %0d", i), int'(sdo_of(four)), int'(exp[i]));
      end
   endtask

   task automatic t_reset();
      check("R1", "sdo_oe idle", int'(sdo_oe8), 0);
      check("R1", "busy_oe idle", int'(busy_oe8), 0);
      check("R1", "busy idle", int'(busy8), 0);
      check("R13", "trial idle", int'(trial8), 0);
   endtask

   task automatic t_single();
      logic [7:0] r;
      logic b1;
      ain[5] = 182; com_v = 33;
      cs_begin();
      check("R1", "busy_oe driven once selected", int'(busy_oe8), 1);
      pulse(1'b0); pulse(1'b0);
      check("R2", "no start on low bits", int'(busy8), 0);
      check("R2", "sdo still off", int'(sdo_oe8), 0);
      send_addr8(1'b1, 1'b1, 1'b1, 1'b0);
      check("R5", "busy after address", int'(busy8), 1);
      check("R3", "pos_ch single", int'(pos8), 5);
      check("R3", "neg_com single", int'(neg_com8), 1);
      check("R6", "sdo_oe settle", int'(sdo_oe8), 1);
      check("R6", "sdo settle low", int'(sdo8), 0);
      check("R13", "trial first probe", int'(trial8), 8'h80);
      read_msb(0, r, b1);
      check("R8", "busy before lsb", int'(b1), 1);
      check("R7", "msb-first result", int'(r), 149);
      check("R8", "busy after lsb", int'(busy8), 0);
      check("R5", "pos_ch kept with sdi high", int'(pos8), 5);
      check_replay(0, "R9", 8'd149);
      pulse(1'b0);
      check("R9", "static after replay", int'(sdo8), 1);
      check("R9", "sdo_oe after replay", int'(sdo_oe8), 1);
      cs_end();
      check("R1", "sdo_oe after cs high", int'(sdo_oe8), 0);
      check("R1", "busy_oe after cs high", int'(busy_oe8), 0);
   endtask

   task automatic t_diff();
      logic [7:0] r;
      logic b1;
      ain[2] = 57; ain[3] = 200;
      cs_begin();
      send_addr8(1'b0, 1'b1, 1'b0, 1'b1);
      check("R4", "pos_ch diff", int'(pos8), 3);
      check("R4", "neg_ch diff", int'(neg8), 2);
      check("R4", "neg_com diff", int'(neg_com8), 0);
      read_msb(0, r, b1);
      check("R7", "diff result", int'(r), 143);
      cs_end();
      cs_begin();
      send_addr8(1'b0, 1'b0, 1'b0, 1'b1);
      check("R4", "pos_ch swapped", int'(pos8), 2);
      check("R4", "neg_ch swapped", int'(neg8), 3);
      read_msb(0, r, b1);
      check("R7", "negative difference gives zero", int'(r), 0);
      cs_end();
   endtask

   task automatic t_hold();
      logic [7:0] r;
      logic b1;
      ain[0] = 8'h59; com_v = 0;
      cs_begin();
      send_addr8(1'b1, 1'b0, 1'b0, 1'b0);
      check("R3", "pos_ch ch0", int'(pos8), 0);
      read_msb(0, r, b1);
      check("R7", "hold scan result", int'(r), 8'h59);
      hold_lsb = 1'b1;
      for (int k = 0; k < 3; k++) begin
         pulse(1'b0);
         check("R10", "lsb held", int'(sdo8), 1);
      end
      hold_lsb = 1'b0;
      check_replay(0, "R10", 8'h59);
      cs_end();
   endtask

   task automatic t_abort();
      logic [7:0] r;
      logic b1;
      ain[6] = 100; com_v = 0;
      cs_begin();
      send_addr8(1'b1, 1'b0, 1'b1, 1'b1);
      check("R3", "pos_ch ch6", int'(pos8), 6);
      pulse(1'b0); pulse(1'b0); pulse(1'b0);
      cs_n = 1'b1;
      wait_clks(4);
      check("R12", "sdo_oe after abort", int'(sdo_oe8), 0);
      check("R12", "busy_oe after abort", int'(busy_oe8), 0);
      check("R12", "busy after abort", int'(busy8), 0);
      cs_begin();
      for (int k = 0; k < 6; k++) pulse(1'b0);
      check("R12", "no conversion without start", int'(busy8), 0);
      check("R12", "sdo off without start", int'(sdo_oe8), 0);
      send_addr8(1'b1, 1'b0, 1'b1, 1'b1);
      read_msb(0, r, b1);
      check("R12", "fresh conversion result", int'(r), 100);
      cs_end();
   endtask

   task automatic t_four();
      logic [7:0] r;
      logic b1;
      ain[3] = 200;
      cs_begin();
      pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b1);
      check("R11", "4ch busy after 3 bits", int'(busy4), 1);
      check("R11", "4ch pos_ch", int'(pos4), 3);
      check("R11", "4ch neg_com", int'(neg_com4), 1);
      check("R11", "4ch settle low", int'(sdo4), 0);
      read_msb(1, r, b1);
      check("R11", "4ch result", int'(r), 200);
      hold_lsb = 1'b1;
      check_replay(1, "R11", 8'd200);
      hold_lsb = 1'b0;
      cs_end();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) ain[i] = 0;
      com_v = 0;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(3);
      t_reset();
      t_single();
      t_diff();
      t_hold();
      t_abort();
      t_four();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule